// File: doc/BRIEF.md
# Cartridge Banked Memory Mapper

This block sits between a 16-bit CPU memory bus and the two storage devices of a cartridge: a paged flash device that holds the BIOS, and a 32 KB battery-backed SRAM. The CPU space is split into four 16 KB pages. Each page is steered to a flash bank by its own bank register. Three fixed 4 KB holes overlay the banked flash with SRAM. One hole always shows SRAM segment 0. The other two show a segment chosen by a frame register, and each of those two frame registers has its own disable flag.

CPU writes that land in a small register area update the mapper's bank and frame registers. Writes to a configuration slot are passed out as a strobe with data, to a configuration register held outside the block. The flash write-enable bit of that external register comes back in as an input. A BIOS-disable input removes the flash from the map completely. The block produces the device addresses, the chip selects, the write strobes and the multiplexed read data. Decode is combinational, and register updates happen on the clock edge.

Top module: `cart_mapper`

## Requirements
- R1: After reset, bank registers 0 to 3 hold 0, 1, 2 and 3, and frame registers 0 and 1 hold 0 and 1. The same values are seen through the device addresses produced by reads.
- R2: A read with no SRAM hit and BIOS enabled asserts flash_cs_o. flash_addr_o equals (bank[cpu_addr[15:14]] & 0x1F) * 0x4000 + cpu_addr[13:0].
- R3: A write to 0x6000–0x63FF with no SRAM hit loads bank register cpu_addr[9:8]. Only data bits 4:0 are kept.
- R4: A write to 0x6500–0x65FF loads frame register 0, and a write to 0x6600–0x66FF loads frame register 1. All 8 data bits are kept.
- R5: Any access to 0x3000–0x3FFF selects SRAM segment 0, whatever the frame registers hold.
- R6: An access to 0x7000–0x7FFF selects the SRAM segment in frame register 0 bits 2:0, unless bit 7 of that register is 1. An access to 0xB000–0xBFFF does the same with frame register 1. A disabled window falls through to the banked flash.
- R7: sram_addr_o equals segment * 0x1000 + cpu_addr[11:0]. An SRAM hit asserts sram_cs_o, and also sram_we_o on a write. An SRAM hit blocks every register and flash action.
- R8: A write to 0x6700–0x67FF with no SRAM hit asserts cfg_wr_o for that cycle, with cfg_data_o equal to the write data. It never writes the flash.
- R9: Any other write asserts flash_cs_o and flash_we_o only when bios_off_i is 0 and flash_wr_en_i is 1. This includes writes to 0x6400–0x64FF.
- R10: cpu_rdata_o returns sram_rdata_i on an SRAM hit. Otherwise it returns flash_rdata_i when bios_off_i is 0, and 0xFF when bios_off_i is 1.
- R11: A register write takes effect at the clock edge that accepts it. An access in the next cycle already uses the new mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_wr_i | input | 1 | CPU write strobe |
| bios_off_i | input | 1 | 1 removes the flash from the map |
| flash_wr_en_i | input | 1 | Flash write-enable bit from the external configuration register |
| flash_rdata_i | input | 8 | Read data from the flash |
| sram_rdata_i | input | 8 | Read data from the SRAM |
| flash_addr_o | output | 19 | Flash byte address |
| flash_cs_o | output | 1 | Flash chip select |
| flash_we_o | output | 1 | Flash write strobe |
| sram_addr_o | output | 15 | SRAM byte address |
| sram_cs_o | output | 1 | SRAM chip select |
| sram_we_o | output | 1 | SRAM write strobe |
| cfg_wr_o | output | 1 | Configuration register write strobe |
| cfg_data_o | output | 8 | Configuration register write data |
| cpu_rdata_o | output | 8 | Read data returned to the CPU |

## Verification
Selects, strobes, device addresses and read data are combinational, so they are due in the same cycle the bus inputs are applied. The bench drives inputs on the falling edge and compares against its model a quarter period later. A bank or frame write changes the map only from the following cycle. For that reason, the reference model applies register updates just after the rising edge, before the next stimulus is applied. Sequences that read back right after each write check that the one-cycle latency holds exactly.

// File: rtl/map_pkg.sv
package map_pkg;
  localparam int unsigned MAP_PAGES   = 4;
  localparam int unsigned MAP_FRAMES  = 2;
  localparam int unsigned PAGE_OFF_W  = 14;
  localparam int unsigned SEG_OFF_W   = 12;
  localparam logic [3:0]  FIXED_HOLE  = 4'h3;
  localparam logic [7:0]  BANK_HI_LO  = 8'h60;
  localparam logic [7:0]  BANK_HI_HI  = 8'h63;
  localparam logic [7:0]  FRAME_HI_LO = 8'h65;
  localparam logic [7:0]  FRAME_HI_HI = 8'h66;
  localparam logic [7:0]  CFG_HI      = 8'h67;

  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_BANK  = 2'd1,
    RGN_FRAME = 2'd2,
    RGN_CFG   = 2'd3
  } reg_rgn_e;
endpackage

// File: rtl/map_rstsync.sv
module map_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/map_regs.sv
module map_regs
  import map_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BANK_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bank_we_i,
  input  logic [1:0]                   bank_idx_i,
  input  logic                         frame_we_i,
  input  logic                         frame_idx_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [MAP_PAGES*BANK_W-1:0]  banks_o,
  output logic [MAP_FRAMES*DATA_W-1:0] frames_o
);
  logic [BANK_W-1:0] bank_q [MAP_PAGES];
  logic [BANK_W-1:0] bank_d [MAP_PAGES];
  logic [DATA_W-1:0] frame_q [MAP_FRAMES];
  logic [DATA_W-1:0] frame_d [MAP_FRAMES];

  always_comb begin
    for (int i = 0; i < MAP_PAGES; i++) begin
      bank_d[i] = bank_q[i];
      if (bank_we_i && (bank_idx_i == 2'(i))) bank_d[i] = wdata_i[BANK_W-1:0];
    end
    for (int j = 0; j < MAP_FRAMES; j++) begin
      frame_d[j] = frame_q[j];
      if (frame_we_i && (frame_idx_i == 1'(j))) frame_d[j] = wdata_i;
    end
  end

  genvar g;
  generate
    for (g = 0; g < MAP_PAGES; g++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         bank_q[g] <= BANK_W'(g);
        else if (bank_we_i) bank_q[g] <= bank_d[g];
      end
      assign banks_o[g*BANK_W +: BANK_W] = bank_q[g];

      // R3, R11: written value visible in the next cycle
      a_r3_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we_i && bank_idx_i == 2'(g)) |=> (banks_o[g*BANK_W +: BANK_W] == $past(wdata_i[BANK_W-1:0])));
    end
    for (g = 0; g < MAP_FRAMES; g++) begin : g_frame
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          frame_q[g] <= DATA_W'(g);
        else if (frame_we_i) frame_q[g] <= frame_d[g];
      end
      assign frames_o[g*DATA_W +: DATA_W] = frame_q[g];

      // R4, R11
      a_r4_frame_load: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_we_i && frame_idx_i == 1'(g)) |=> (frames_o[g*DATA_W +: DATA_W] == $past(wdata_i)));
    end
  endgenerate

  // R3: registers hold without a load
  a_r3_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_we_i) |=> $stable(banks_o));
  a_r4_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_we_i) |=> $stable(frames_o));
endmodule

// File: rtl/map_decode.sv
module map_decode
  import map_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BANK_W = 5,
  parameter int unsigned SEG_W  = 3,
  localparam int unsigned FLASH_AW = BANK_W + PAGE_OFF_W,
  localparam int unsigned SRAM_AW  = SEG_W + SEG_OFF_W
) (
  input  logic [15:0]                  cpu_addr_i,
  input  logic                         cpu_rd_i,
  input  logic                         cpu_wr_i,
  input  logic                         bios_off_i,
  input  logic                         flash_wr_en_i,
  input  logic [MAP_PAGES*BANK_W-1:0]  banks_i,
  input  logic [MAP_FRAMES*DATA_W-1:0] frames_i,
  output logic [FLASH_AW-1:0]          flash_addr_o,
  output logic                         flash_cs_o,
  output logic                         flash_we_o,
  output logic [SRAM_AW-1:0]           sram_addr_o,
  output logic                         sram_cs_o,
  output logic                         sram_we_o,
  output logic                         bank_we_o,
  output logic                         frame_we_o,
  output logic                         cfg_we_o
);
  logic             hit;
  logic [SEG_W-1:0] seg;
  logic [7:0]       hi;
  reg_rgn_e         rgn;
  logic [BANK_W-1:0] cur_bank;

  assign hi = cpu_addr_i[15:8];

  always_comb begin
    hit = 1'b0;
    seg = '0;
    if (cpu_addr_i[15:12] == FIXED_HOLE) begin
      hit = 1'b1;
    end else begin
      for (int f = 0; f < MAP_FRAMES; f++) begin
        if (!hit && (cpu_addr_i[15:12] == 4'(7 + 4*f)) &&
            !frames_i[f*DATA_W + DATA_W - 1]) begin
          hit = 1'b1;
          seg = frames_i[f*DATA_W +: SEG_W];
        end
      end
    end
  end

  always_comb begin
    if (hi >= BANK_HI_LO && hi <= BANK_HI_HI)        rgn = RGN_BANK;
    else if (hi >= FRAME_HI_LO && hi <= FRAME_HI_HI) rgn = RGN_FRAME;
    else if (hi == CFG_HI)                           rgn = RGN_CFG;
    else                                             rgn = RGN_NONE;
  end

  assign cur_bank     = banks_i[cpu_addr_i[15:14]*BANK_W +: BANK_W];
  assign flash_addr_o = {cur_bank, cpu_addr_i[PAGE_OFF_W-1:0]};
  assign sram_addr_o  = {seg, cpu_addr_i[SEG_OFF_W-1:0]};

  assign sram_cs_o  = hit && (cpu_rd_i || cpu_wr_i);
  assign sram_we_o  = hit && cpu_wr_i;
  assign bank_we_o  = !hit && cpu_wr_i && (rgn == RGN_BANK);
  assign frame_we_o = !hit && cpu_wr_i && (rgn == RGN_FRAME);
  assign cfg_we_o   = !hit && cpu_wr_i && (rgn == RGN_CFG);
  assign flash_we_o = !hit && cpu_wr_i && (rgn == RGN_NONE) && !bios_off_i && flash_wr_en_i;
  assign flash_cs_o = flash_we_o || (!hit && cpu_rd_i && !bios_off_i);
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
  import map_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BANK_W = 5,
  parameter int unsigned SEG_W  = 3,
  localparam int unsigned FLASH_AW = BANK_W + PAGE_OFF_W,
  localparam int unsigned SRAM_AW  = SEG_W + SEG_OFF_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [15:0]         cpu_addr_i,
  input  logic [DATA_W-1:0]   cpu_wdata_i,
  input  logic                cpu_rd_i,
  input  logic                cpu_wr_i,
  input  logic                bios_off_i,
  input  logic                flash_wr_en_i,
  input  logic [DATA_W-1:0]   flash_rdata_i,
  input  logic [DATA_W-1:0]   sram_rdata_i,
  output logic [FLASH_AW-1:0] flash_addr_o,
  output logic                flash_cs_o,
  output logic                flash_we_o,
  output logic [SRAM_AW-1:0]  sram_addr_o,
  output logic                sram_cs_o,
  output logic                sram_we_o,
  output logic                cfg_wr_o,
  output logic [DATA_W-1:0]   cfg_data_o,
  output logic [DATA_W-1:0]   cpu_rdata_o
);
  logic                         rst_sync_n;
  logic                         bank_we, frame_we, cfg_we;
  logic [MAP_PAGES*BANK_W-1:0]  banks;
  logic [MAP_FRAMES*DATA_W-1:0] frames;

  map_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  map_regs #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .bank_we_i   (bank_we),
    .bank_idx_i  (cpu_addr_i[9:8]),
    .frame_we_i  (frame_we),
    .frame_idx_i (cpu_addr_i[9]),
    .wdata_i     (cpu_wdata_i),
    .banks_o     (banks),
    .frames_o    (frames)
  );

  map_decode #(.DATA_W(DATA_W), .BANK_W(BANK_W), .SEG_W(SEG_W)) u_dec (
    .cpu_addr_i    (cpu_addr_i),
    .cpu_rd_i      (cpu_rd_i),
    .cpu_wr_i      (cpu_wr_i),
    .bios_off_i    (bios_off_i),
    .flash_wr_en_i (flash_wr_en_i),
    .banks_i       (banks),
    .frames_i      (frames),
    .flash_addr_o  (flash_addr_o),
    .flash_cs_o    (flash_cs_o),
    .flash_we_o    (flash_we_o),
    .sram_addr_o   (sram_addr_o),
    .sram_cs_o     (sram_cs_o),
    .sram_we_o     (sram_we_o),
    .bank_we_o     (bank_we),
    .frame_we_o    (frame_we),
    .cfg_we_o      (cfg_we)
  );

  assign cfg_wr_o   = cfg_we;
  assign cfg_data_o = cpu_wdata_i;

  always_comb begin
    if (sram_cs_o)        cpu_rdata_o = sram_rdata_i;
    else if (!bios_off_i) cpu_rdata_o = flash_rdata_i;
    else                  cpu_rdata_o = {DATA_W{1'b1}};
  end

  // R7, R8: at most one target per access
  a_r7_one_target: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({sram_cs_o, flash_cs_o, cfg_wr_o}));
  // R2: page offset passes through unchanged
  a_r2_offset: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flash_cs_o |-> (flash_addr_o[PAGE_OFF_W-1:0] == cpu_addr_i[PAGE_OFF_W-1:0]));
  // R5: fixed hole is always segment 0
  a_r5_fixed_hole: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_rd_i && cpu_addr_i[15:12] == FIXED_HOLE) |-> (sram_cs_o && sram_addr_o[SRAM_AW-1:SEG_OFF_W] == '0));
  // R9: disabled BIOS never sees a write
  a_r9_bios_off: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bios_off_i |-> (!flash_we_o && !flash_cs_o));
  // R10: open bus value
  a_r10_open_bus: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_rd_i && !sram_cs_o && bios_off_i) |-> (cpu_rdata_o == {DATA_W{1'b1}}));
endmodule

// File: tb/tb_cart_mapper.sv
module tb_cart_mapper;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_rd, cpu_wr, bios_off, flash_wr_en;
  logic [7:0]  flash_rdata, sram_rdata;
  logic [18:0] flash_addr;
  logic        flash_cs, flash_we;
  logic [14:0] sram_addr;
  logic        sram_cs, sram_we, cfg_wr;
  logic [7:0]  cfg_data, cpu_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int bk [4];
  int fr [2];

  assign flash_rdata = cpu_addr[15:8] ^ cpu_addr[7:0];
  assign sram_rdata  = cpu_addr[7:0] ^ 8'h5A;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_mapper dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_rd_i(cpu_rd), .cpu_wr_i(cpu_wr), .bios_off_i(bios_off),
    .flash_wr_en_i(flash_wr_en), .flash_rdata_i(flash_rdata), .sram_rdata_i(sram_rdata),
    .flash_addr_o(flash_addr), .flash_cs_o(flash_cs), .flash_we_o(flash_we),
    .sram_addr_o(sram_addr), .sram_cs_o(sram_cs), .sram_we_o(sram_we),
    .cfg_wr_o(cfg_wr), .cfg_data_o(cfg_data), .cpu_rdata_o(cpu_rdata)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at addr=%04h", tag, what, act, exp, cpu_addr);
    end
  endtask

  // one bus cycle; reference model evaluated and updated behaviourally
  task automatic cyc(input string tag, input int addr, input int data,
                     input bit rd, input bit wr, input bit boff, input bit fwe);
    bit sh, inb, inf, inc, ecs, ewe;
    int seg, top, hi;
    @(negedge clk);
    cpu_addr = 16'(addr); cpu_wdata = 8'(data);
    cpu_rd = rd; cpu_wr = wr; bios_off = boff; flash_wr_en = fwe;
    #(CLK_PERIOD/4);
    top = addr / 4096; hi = addr / 256;
    sh = 0; seg = 0;
    if (top == 3) sh = 1;
    else if (top == 7 && (fr[0] & 128) == 0) begin sh = 1; seg = fr[0] & 7; end
    else if (top == 11 && (fr[1] & 128) == 0) begin sh = 1; seg = fr[1] & 7; end
    inb = hi >= 'h60 && hi <= 'h63;
    inf = hi == 'h65 || hi == 'h66;
    inc = hi == 'h67;
    ewe = !sh && wr && !inb && !inf && !inc && !boff && fwe;
    ecs = ewe || (!sh && rd && !boff);
    chk(tag, "sram_cs", int'(sram_cs), int'(sh && (rd || wr)));
    chk(tag, "sram_we", int'(sram_we), int'(sh && wr));
    chk(tag, "flash_cs", int'(flash_cs), int'(ecs));
    chk(tag, "flash_we", int'(flash_we), int'(ewe));
    chk(tag, "cfg_wr", int'(cfg_wr), int'(!sh && wr && inc));
    if (sh && (rd || wr)) chk(tag, "sram_addr", int'(sram_addr), seg * 4096 + (addr % 4096));
    if (ecs) chk(tag, "flash_addr", int'(flash_addr), (bk[addr / 16384] % 32) * 16384 + (addr % 16384));
    if (!sh && wr && inc) chk(tag, "cfg_data", int'(cfg_data), data);
    if (rd) chk(tag, "rdata", int'(cpu_rdata),
                sh ? ((addr % 256) ^ 'h5A) : (!boff ? (((addr / 256) % 256) ^ (addr % 256)) : 255));
    @(posedge clk); #1;
    if (wr && !sh) begin
      if (inb) bk[(addr / 256) % 4] = data;
      if (inf) fr[(addr / 512) % 2] = data;
    end
  endtask

  task automatic rd_(input string tag, input int a);          cyc(tag, a, 0, 1, 0, 0, 0); endtask
  task automatic wr_(input string tag, input int a, input int d); cyc(tag, a, d, 0, 1, 0, 0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cpu_addr = 0; cpu_wdata = 0; cpu_rd = 0; cpu_wr = 0;
    bios_off = 0; flash_wr_en = 0;
    for (int i = 0; i < 4; i++) bk[i] = i;
    for (int i = 0; i < 2; i++) fr[i] = i;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset mapping through page reads and frame windows
    rd_("R1", 'h0000); rd_("R1", 'h4001); rd_("R1", 'h8abc); rd_("R1", 'hc123);
    rd_("R1", 'h7010); rd_("R1", 'hb456);
    // R5: fixed hole
    rd_("R5", 'h3000); rd_("R5", 'h3fff);

    // R3, R11: bank loads with immediate reads
    wr_("R3", 'h6000, 'he7); rd_("R11", 'h0123);
    wr_("R3", 'h61ff, 9);    rd_("R11", 'h4567);
    wr_("R3", 'h6234, 31);   rd_("R11", 'h8000);
    wr_("R3", 'h6300, 'h20); rd_("R11", 'hffff);

    // R4, R6: frame loads, disable flag
    wr_("R4", 'h6500, 5);    rd_("R6", 'h7fff);
    wr_("R4", 'h66aa, 'h83); rd_("R6", 'hb000);
    wr_("R4", 'h66ff, 7);    rd_("R6", 'hb800);
    wr_("R4", 'h65ff, 'h80); rd_("R6", 'h7000);
    rd_("R5", 'h3abc);

    // R7: SRAM priority over flash writes and register area
    wr_("R7", 'h3abc, 'h11);
    wr_("R7", 'hb123, 'h22);
    cyc("R7", 'hb124, 'h23, 0, 1, 0, 1);
    wr_("R4", 'h6500, 6); rd_("R7", 'h7444);

    // R8: configuration strobe, no flash write even when enabled
    cyc("R8", 'h6700, 'h10, 0, 1, 0, 1);
    cyc("R8", 'h67ff, 'h33, 0, 1, 0, 1);

    // R9: flash write gating
    cyc("R9", 'h8000, 'h44, 0, 1, 0, 0);
    cyc("R9", 'h8001, 'h45, 0, 1, 0, 1);
    cyc("R9", 'h8002, 'h46, 0, 1, 1, 1);
    cyc("R9", 'h6400, 'h47, 0, 1, 0, 1);
    cyc("R9", 'h64ff, 'h48, 0, 1, 0, 1);
    rd_("R9", 'h0400);

    // R10: open bus with BIOS off, SRAM still served
    cyc("R10", 'h0000, 0, 1, 0, 1, 0);
    cyc("R10", 'hc000, 0, 1, 0, 1, 0);
    cyc("R10", 'h3123, 0, 1, 0, 1, 0);
    cyc("R10", 'hb222, 0, 1, 0, 1, 0);

    // R2: sweep of reads across the whole space
    for (int a = 0; a < 65536; a += 'h0301) rd_("R2", a);
    for (int a = 7; a < 65536; a += 'h0b03) cyc("R10", a, 0, 1, 0, 1, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule